// File: doc/BRIEF.md
# Nibble-to-Dibit Transmit Adapter

This block sits between a MAC that produces transmit data four bits at a time and a reduced-pin PHY that takes two bits per clock. Everything runs from one 50 MHz reference clock. Nibbles arrive through a valid/ready handshake. Each accepted nibble leaves as two dibits, bits 1:0 first and then bits 3:2. A transmit-enable output frames each burst of dibits.

The `slow_mode` input selects the line speed. With `slow_mode` low (100 Mb/s), the adapter sends one dibit on every reference clock, which drains one nibble every two cycles. With `slow_mode` high (10 Mb/s), an internal divide-by-`SLOW_DIV` enable (default 10) paces the state machine, so each dibit stays on the output for ten reference clocks.

A three-state machine is the core of the design:
- `ST_IDLE`: the output is quiet.
- `ST_LOW`: the lower dibit is driven.
- `ST_HIGH`: the upper dibit is driven.

The state advances only on an enable tick. The transitions are:
- IDLE→LOW: a nibble is accepted while idle.
- LOW→HIGH: always taken on the tick.
- HIGH→LOW: a next nibble is accepted at the tick.
- HIGH→IDLE: no nibble is offered at the tick.

Top module: `rmii_tx_adapter`

## Requirements
- R1: After reset `out_en` is 0 and `out_dibit` is 2'b00. In fast mode `in_ready` is 1 while idle.
- R2: Each accepted nibble (accepted when `in_valid` and `in_ready` are both 1 at a rising edge) produces exactly two dibits. The first is nibble bits [1:0] and the second is bits [3:2].
- R3: With `slow_mode`=0 each dibit lasts one clock. The first dibit appears in the cycle right after the accepting edge.
- R4: With `slow_mode`=1 each dibit lasts exactly `SLOW_DIV` (10) clocks. While idle, `in_ready` is high on only one cycle in every 10.
- R5: `out_en` rises with the first dibit of a burst and falls right after the second dibit of its last nibble. While `out_en` is 0, `out_dibit` is 2'b00.
- R6: `in_ready` is never high while the first dibit of a nibble is on the output. While `out_en` is 1, it is high on exactly one cycle per nibble: the final cycle of that nibble's second dibit.
- R7: While `in_valid` is 0, changes on `in_data` have no effect and the output stays idle.
- R8: If a nibble is offered when the second dibit ends, its first dibit follows with no idle cycle in between. If `in_valid` drops between nibbles, the burst ends and a new `out_en` rise starts the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | 1 = 10 Mb/s pacing, 0 = 100 Mb/s |
| in_valid | input | 1 | Nibble offered |
| in_data | input | 4 | Nibble to transmit |
| in_ready | output | 1 | Adapter takes the nibble at this edge |
| out_en | output | 1 | Transmit enable towards the PHY |
| out_dibit | output | 2 | Dibit towards the PHY |

## Verification
Two events can fall in the same cycle: the end of a nibble's second dibit and the acceptance of the next nibble. In that cycle the HIGH→LOW transition must hand over without a gap or a repeat. The bench provokes this by streaming back-to-back nibbles in both speed modes, and by dropping `in_valid` for a few cycles mid-stream. It judges the result by comparing the whole captured dibit stream, stretched by the hold length, with the stream expected from the nibble table. It also counts the `out_en` rises and the `in_ready` pulses seen while enable is high.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    localparam int NIB_W = 4;
    localparam int DIB_W = 2;
    localparam int PARTS = NIB_W / DIB_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } tx_state_t;
endpackage

// File: rtl/dtx_rate_gen.sv
module dtx_rate_gen #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_mode,
    output logic tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !slow_mode) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        tick = slow_mode ? (cnt == LAST) : 1'b1;
    end

    generate
        if (SLOW_DIV > 1) begin : g_spacing
            // R4: in slow mode two enables never fall in adjacent cycles
            assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (slow_mode && $past(slow_mode) && tick) |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dtx_fsm.sv
module dtx_fsm
    import dtx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      in_valid,
    output logic      in_ready,
    output logic      load,
    output tx_state_t state
);
    tx_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        in_ready = 1'b0;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = tick;
                if (tick && in_valid) begin
                    load     = 1'b1;
                    state_nx = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    state_nx = ST_HIGH;
                end
            end
            ST_HIGH: begin
                in_ready = tick;
                if (tick) begin
                    if (in_valid) begin
                        load     = 1'b1;
                        state_nx = ST_LOW;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R6: no acceptance while the first dibit is out
    assert_low_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> !in_ready);
    // R2: the first dibit is always followed by the second
    assert_low_to_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && tick) |=> (state == ST_HIGH));
    // R8: an accepted nibble starts its first dibit on the next cycle
    assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (state == ST_LOW));
endmodule

// File: rtl/dtx_dibit_path.sv
module dtx_dibit_path
    import dtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NIB_W-1:0] in_data,
    input  tx_state_t        state,
    output logic             out_en,
    output logic [DIB_W-1:0] out_dibit
);
    logic [NIB_W-1:0] nib_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q <= '0;
        end else if (load) begin
            nib_q <= in_data;
        end
    end

    always_comb begin
        out_en    = (state != ST_IDLE);
        out_dibit = '0;
        unique case (state)
            ST_LOW:  out_dibit = nib_q[DIB_W-1:0];
            ST_HIGH: out_dibit = nib_q[NIB_W-1:DIB_W];
            default: out_dibit = '0;
        endcase
    end
endmodule

// File: rtl/rmii_tx_adapter.sv
module rmii_tx_adapter
    import dtx_pkg::*;
#(
    parameter int SLOW_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    input  logic       in_valid,
    input  logic [3:0] in_data,
    output logic       in_ready,
    output logic       out_en,
    output logic [1:0] out_dibit
);
    logic      tick;
    logic      load;
    tx_state_t state;

    dtx_rate_gen #(.SLOW_DIV(SLOW_DIV)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .tick      (tick)
    );

    dtx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .state    (state)
    );

    dtx_dibit_path u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .in_data   (in_data),
        .state     (state),
        .out_en    (out_en),
        .out_dibit (out_dibit)
    );

    // R5: quiet data lines while enable is low
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (out_dibit == 2'b00));
    // R4: without an enable tick the dibit does not move
    assert_dibit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !tick) |=> $stable(out_dibit));
endmodule

// File: tb/rmii_tx_adapter_bench.sv
module rmii_tx_adapter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_data = 4'h0;
    logic       in_ready;
    logic       out_en;
    logic [1:0] out_dibit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rmii_tx_adapter u_rmii_tx_adapter (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_en(out_en), .out_dibit(out_dibit)
    );

    // {nibble, first dibit, second dibit}
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        {4'h0, 2'b00, 2'b00}, {4'hF, 2'b11, 2'b11}, {4'h5, 2'b01, 2'b01},
        {4'hA, 2'b10, 2'b10}, {4'h1, 2'b01, 2'b00}, {4'h4, 2'b00, 2'b01},
        {4'h6, 2'b10, 2'b01}, {4'h9, 2'b01, 2'b10}, {4'hC, 2'b00, 2'b11},
        {4'h3, 2'b11, 2'b00}, {4'hE, 2'b10, 2'b11}, {4'h7, 2'b11, 2'b01}
    };

    logic [1:0] got_q[$];
    bit mon_on = 1'b0;
    bit prev_en = 1'b0;
    int rises = 0;
    int rdy_hi = 0;
    int idle_bad = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_en) got_q.push_back(out_dibit);
            if (out_en && in_ready) rdy_hi++;
            if (out_en && !prev_en) rises++;
            if (!out_en && out_dibit != 2'b00) idle_bad++;
            prev_en = out_en;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] nib);
        bit acc;
        in_valid = 1'b1;
        in_data  = nib;
        acc = 1'b0;
        while (!acc) begin
            acc = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = ~nib;
    endtask

    task automatic run_burst(input bit slow, input int gap_after, input int exp_rises);
        logic [1:0] exp_q[$];
        int hold, bad;
        hold = slow ? 10 : 1;
        got_q.delete();
        rises = 0; rdy_hi = 0; idle_bad = 0; prev_en = 1'b0;
        slow_mode = slow;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][7:4]);
            if (i == gap_after) repeat (25) @(negedge clk);
            for (int k = 0; k < hold; k++) exp_q.push_back(VEC[i][3:2]);
            for (int k = 0; k < hold; k++) exp_q.push_back(VEC[i][1:0]);
        end
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        check(got_q.size() == exp_q.size(), slow ? "R4 stream length" : "R3 stream length",
              got_q.size(), exp_q.size());
        bad = 0;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] != exp_q[i]) bad++;
        check(bad == 0, "R2 dibit order and content", bad, 0);
        check(rises == exp_rises, "R5/R8 out_en rises", rises, exp_rises);
        check(rdy_hi == NV, "R6 ready pulses while enabled", rdy_hi, NV);
        check(idle_bad == 0, "R5 dibit nonzero while disabled", idle_bad, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_en == 1'b0, "R1 out_en after reset", out_en, 0);
        check(out_dibit == 2'b00, "R1 out_dibit after reset", out_dibit, 0);
        check(in_ready == 1'b1, "R1 in_ready idle fast", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: data toggles without valid
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            in_data = 4'(i);
            @(negedge clk);
            if (out_en || out_dibit != 2'b00) cnt++;
        end
        check(cnt == 0, "R7 output idle without valid", cnt, 0);

        // R3: first dibit right after the accepting edge
        in_valid = 1'b1; in_data = 4'b1110;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_en == 1'b1 && out_dibit == 2'b10, "R3 first dibit next cycle", out_dibit, 2);
        check(in_ready == 1'b0, "R6 not ready during first dibit", in_ready, 0);
        @(negedge clk);
        check(out_dibit == 2'b11 && in_ready == 1'b1, "R2 second dibit upper bits", out_dibit, 3);
        @(negedge clk);
        check(out_en == 1'b0, "R5 enable falls after last dibit", out_en, 0);

        // table-driven streams: back-to-back and with a gap, both speeds
        run_burst(1'b0, -1, 1);
        run_burst(1'b0, 5, 2);
        run_burst(1'b1, -1, 1);
        run_burst(1'b1, 3, 2);

        // R4: slow idle ready on one cycle in ten
        slow_mode = 1'b1;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (in_ready) cnt++;
            @(negedge clk);
        end
        check(cnt == 4, "R4 idle ready pulses in slow mode", cnt, 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule